// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Phase Offset

This block divides a fast source clock down to one output group clock. A 4-bit select code picks the division ratio from eleven fixed values, five of which are multiples of five. A 5-bit phase field lets the output edge lead a reference group that runs at the same ratio. The step size depends on the ratio: one source cycle for power-of-two ratios, and five source cycles for ratios that are multiples of five. A second instance with a zero phase field serves as the reference group.

The select code and phase field are read only on the cycle that a resync strobe is high. On that cycle the ratio is captured and the internal counter is preloaded with the phase offset. All groups that are resynced on the same edge stay aligned. A group enable forces the output low while the counter keeps running, so the phase is kept.

Top module: `pd_postdiv`

## Requirements
- R1: Select codes map to ratios: 0000=1, 0001=2, 0010=4, 0011=5, 0100=8, 0101=10, 0110=16, 0111=20, 1000=32, 1001=40, 1010=80. The output period is the selected ratio in source cycles.
- R2: Select codes 1011 to 1111 divide by 1.
- R3: While reset is low the output is low. Reset sets the captured code to 0111 (divide by 20) and the counter to 0. With the enable high, the output at the k-th rising edge after reset release is high when (k mod 20) < 10.
- R4: For a ratio R > 1 the output is high while the counter is below (R+1)/2. Even ratios therefore give 50% duty, and ratio 5 gives 3 cycles high and 2 low. At ratio 1 the output is the source clock, gated by the enable.
- R5: For ratios 10, 20, 40 and 80 the step index is phase bits [1], [2:1], [3:1] and [4:1] respectively. Bit 0 is ignored. The output leads by 5 × index source cycles.
- R6: For ratios 2, 4, 8, 16 and 32 the step index is the low 1, 2, 3, 4 and 5 phase bits respectively. The output leads by index source cycles.
- R7: For ratios 1 and 5 the phase field has no effect.
- R8: When the group enable is 0 the output is low from the next rising edge. The counter keeps running, so the output resumes in its former phase.
- R9: A resync strobe captures the select code and preloads the counter with the offset. Changes to the select code or phase field without a strobe have no effect. After the strobe edge, the output at the j-th rising edge is high when ((offset + j) mod R) < (R+1)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 4 | Division ratio select code |
| phase_sel | input | PH_W (5) | Phase step field |
| grp_en | input | 1 | Group enable; 0 holds the output low |
| resync | input | 1 | Capture select and preload the phase offset |
| div_clk | output | 1 | Divided group clock |

## Verification
On every cycle, the assertions check the following: the counter stays within the active ratio, the captured code changes only on a strobe, and the strobe loads the counter with the computed offset. They also check that the offset stays on the step grid and below the ratio, that ratios 1 and 5 take no offset, that a disabled group stays low, and that the output level tracks the counter. The bench's sweeps over every select code and every phase value are needed to show the cycle-exact waveforms. These cover the exact lead, the per-ratio bit selection of the phase field, the value after reset, and the gated source clock at ratio 1. A scenario that changes the inputs without a strobe shows they are ignored, and one that drops the enable shows the phase is kept.

// File: rtl/pd_pkg.sv
package pd_pkg;
   localparam int RATIO_MAX = 80;
   localparam int RATIO_W   = $clog2(RATIO_MAX + 1);
   localparam int STEP_W    = 6;
   localparam int SEL_W     = 4;
   localparam int PH_BITS   = 5;
   localparam int STEP_MULT = 5;

   typedef struct packed {
      logic [RATIO_W-1:0] ratio;
      logic [STEP_W-1:0]  steps;
      logic               mult5;
   } ratio_info_t;

   function automatic ratio_info_t decode_sel(input logic [SEL_W-1:0] code);
      ratio_info_t r;
      case (code)
         4'd0:    r = '{RATIO_W'(1),  STEP_W'(1),  1'b0};
         4'd1:    r = '{RATIO_W'(2),  STEP_W'(2),  1'b0};
         4'd2:    r = '{RATIO_W'(4),  STEP_W'(4),  1'b0};
         4'd3:    r = '{RATIO_W'(5),  STEP_W'(1),  1'b1};
         4'd4:    r = '{RATIO_W'(8),  STEP_W'(8),  1'b0};
         4'd5:    r = '{RATIO_W'(10), STEP_W'(2),  1'b1};
         4'd6:    r = '{RATIO_W'(16), STEP_W'(16), 1'b0};
         4'd7:    r = '{RATIO_W'(20), STEP_W'(4),  1'b1};
         4'd8:    r = '{RATIO_W'(32), STEP_W'(32), 1'b0};
         4'd9:    r = '{RATIO_W'(40), STEP_W'(8),  1'b1};
         4'd10:   r = '{RATIO_W'(80), STEP_W'(16), 1'b1};
         default: r = '{RATIO_W'(1),  STEP_W'(1),  1'b0};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pd_ratio_decode.sv
module pd_ratio_decode
   import pd_pkg::*;
(
   input  logic [SEL_W-1:0]   code,
   output logic [RATIO_W-1:0] ratio,
   output logic [STEP_W-1:0]  steps,
   output logic               mult5
);
   ratio_info_t info;
   always_comb begin
      info  = decode_sel(code);
      ratio = info.ratio;
      steps = info.steps;
      mult5 = info.mult5;
   end
endmodule

// File: rtl/pd_phase_map.sv
module pd_phase_map #(
   parameter int W      = 7,
   parameter int SW     = 6,
   parameter int PH_W   = 5,
   parameter int STEP   = 5
) (
   input  logic [SW-1:0]   steps,
   input  logic            mult5,
   input  logic [PH_W-1:0] phase,
   output logic [W-1:0]    offset
);
   logic [PH_W-1:0] mask;
   logic [PH_W-1:0] shifted;
   logic [PH_W-1:0] idx;

   always_comb begin
      mask    = PH_W'(steps - SW'(1));
      shifted = mult5 ? (phase >> 1) : phase;
      idx     = shifted & mask;
      offset  = mult5 ? (W'(idx) * W'(STEP)) : W'(idx);
   end
endmodule

// File: rtl/pd_counter.sv
module pd_counter #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ratio,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         div_q
);
   logic [W-1:0] half;
   logic [W-1:0] nxt;

   always_comb begin
      half = W'((ratio + W'(1)) >> 1);
      if (load)
         nxt = load_val;
      else if (cnt >= ratio - W'(1))
         nxt = '0;
      else
         nxt = cnt + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_q <= 1'b0;
      end else begin
         cnt   <= nxt;
         div_q <= en && (nxt < half);
      end
   end
endmodule

// File: rtl/pd_postdiv.sv
module pd_postdiv #(
   parameter int          PH_W      = 5,
   parameter logic [3:0]  DEF_CODE  = 4'b0111,
   parameter bit          DIRECT_R1 = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      ratio_sel,
   input  logic [PH_W-1:0] phase_sel,
   input  logic            grp_en,
   input  logic            resync,
   output logic            div_clk
);
   import pd_pkg::*;
   localparam int W = RATIO_W;

   if (PH_W != PH_BITS) begin : g_bad_ph
      $error("pd_postdiv: PH_W must equal %0d", PH_BITS);
   end
   if (DEF_CODE > 4'd10) begin : g_bad_def
      $error("pd_postdiv: DEF_CODE out of range");
   end

   logic [SEL_W-1:0]  code_q;
   logic [W-1:0]      ratio_live, ratio_act, ratio_eff, offset, cnt;
   logic [STEP_W-1:0] steps_live, steps_act;
   logic              mult5_live, mult5_act, div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= DEF_CODE;
      else if (resync) code_q <= ratio_sel;
   end

   pd_ratio_decode u_dec_live (
      .code(ratio_sel), .ratio(ratio_live), .steps(steps_live), .mult5(mult5_live));
   pd_ratio_decode u_dec_act (
      .code(code_q), .ratio(ratio_act), .steps(steps_act), .mult5(mult5_act));

   pd_phase_map #(.W(W), .SW(STEP_W), .PH_W(PH_W), .STEP(STEP_MULT)) u_phase (
      .steps(steps_live), .mult5(mult5_live), .phase(phase_sel), .offset(offset));

   assign ratio_eff = resync ? ratio_live : ratio_act;

   pd_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ratio(ratio_eff), .load(resync),
      .load_val(offset), .en(grp_en), .cnt(cnt), .div_q(div_q));

   if (DIRECT_R1) begin : g_r1_direct
      logic en_n;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) en_n <= 1'b0;
         else        en_n <= grp_en;
      end
      assign div_clk = (ratio_act == W'(1)) ? (clk & en_n) : div_q;
   end else begin : g_r1_level
      assign div_clk = div_q;
   end
endmodule

// File: rtl/pd_postdiv_chk.sv
module pd_postdiv_chk #(
   parameter int W  = 7,
   parameter int SW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          resync,
   input logic          grp_en,
   input logic [3:0]    code_q,
   input logic [W-1:0]  ratio_live,
   input logic          mult5_live,
   input logic [W-1:0]  ratio_act,
   input logic [SW-1:0] steps_act,
   input logic          mult5_act,
   input logic [W-1:0]  offset,
   input logic [W-1:0]  cnt,
   input logic          div_q
);
   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < ratio_act) && (W'(steps_act) <= ratio_act));
   assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q > 4'd10) |-> (ratio_act == W'(1)));
   assert_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_en && !resync) |=> (div_q == (cnt < W'((ratio_act + W'(1)) >> 1))));
   assert_five_grid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mult5_live |-> ((offset % W'(5)) == '0));
   assert_off_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      offset < ratio_live);
   assert_no_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ratio_live == W'(1)) || (ratio_live == W'(5))) |-> (offset == '0));
   assert_ratio5_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mult5_act && ratio_act == W'(5) && grp_en && !resync && cnt == W'(2)) |=> !div_q);
   assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_en |=> !div_q);
   assert_resync_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (cnt == $past(offset)));
   assert_hold_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !resync |=> $stable(code_q));
endmodule

bind pd_postdiv pd_postdiv_chk #(.W(pd_pkg::RATIO_W), .SW(pd_pkg::STEP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .resync(resync), .grp_en(grp_en), .code_q(code_q),
   .ratio_live(ratio_live), .mult5_live(mult5_live), .ratio_act(ratio_act),
   .steps_act(steps_act), .mult5_act(mult5_act), .offset(offset), .cnt(cnt),
   .div_q(div_q));

// File: tb/pd_postdiv_tb.sv
`timescale 1ns/1ps
module pd_postdiv_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ratio_sel = 4'd0;
   logic [4:0] phase_sel = 5'd0;
   logic       grp_en = 1'b1;
   logic       resync = 1'b0;
   logic       div_clk;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   pd_postdiv u_dut (
      .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .phase_sel(phase_sel),
      .grp_en(grp_en), .resync(resync), .div_clk(div_clk));

   function automatic int b_ratio(input int c);
      case (c)
         0: return 1;   1: return 2;   2: return 4;   3: return 5;
         4: return 8;   5: return 10;  6: return 16;  7: return 20;
         8: return 32;  9: return 40;  10: return 80;
         default: return 1;
      endcase
   endfunction

   function automatic int b_off(input int c, input int p);
      int r = b_ratio(c);
      if (r % 5 == 0) return ((p >> 1) % (r / 5)) * 5;
      return p % r;
   endfunction

   function automatic bit b_level(input int r, input int pos);
      return ((pos % r) < ((r + 1) / 2));
   endfunction

   function automatic string req_of(input int c, input int p);
      int r = b_ratio(c);
      if (c > 10)                 return "R2";
      if (r == 1 || r == 5)       return "R7";
      if (p == 0)                 return "R1";
      if (r % 5 == 0)             return "R5";
      return "R6";
   endfunction

   task automatic chk(input bit got, input bit exp, input string req, input string ctx);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: got %0b expected %0b", req, ctx, got, exp);
      end
   endtask

   task automatic run_combo(input int c, input int p);
      int r   = b_ratio(c);
      int off = b_off(c, p);
      string req = req_of(c, p);
      @(negedge clk);
      ratio_sel = 4'(c); phase_sel = 5'(p); resync = 1'b1;
      @(posedge clk); #1;
      chk(div_clk, b_level(r, off), req, $sformatf("code=%0d ph=%0d j=0", c, p));
      @(negedge clk); resync = 1'b0;
      for (int j = 1; j < 2 * r; j++) begin
         @(posedge clk); #1;
         chk(div_clk, b_level(r, off + j), req, $sformatf("code=%0d ph=%0d j=%0d", c, p, j));
      end
      if (r == 1) begin
         @(negedge clk); #1;
         chk(div_clk, 1'b0, "R4", $sformatf("ratio1 low half code=%0d", c));
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R3: reset state and default divide-by-20
      #11;
      chk(div_clk, 1'b0, "R3", "output during reset");
      @(negedge clk); rst_n = 1'b1;
      for (int k = 1; k <= 40; k++) begin
         @(posedge clk); #1;
         chk(div_clk, b_level(20, k), "R3", $sformatf("default ratio k=%0d", k));
      end

      // R1, R2, R4, R5, R6, R7: every code with every phase value
      for (int c = 0; c < 16; c++)
         for (int p = 0; p < 32; p++)
            run_combo(c, p);

      // R9: select and phase changes without a strobe are ignored
      @(negedge clk); ratio_sel = 4'd3; phase_sel = 5'd0; resync = 1'b1;
      @(posedge clk); #1;
      chk(div_clk, b_level(5, 0), "R9", "strobe to ratio 5");
      @(negedge clk); resync = 1'b0; ratio_sel = 4'd10; phase_sel = 5'd7;
      for (int j = 1; j <= 20; j++) begin
         @(posedge clk); #1;
         chk(div_clk, b_level(5, j), "R9", $sformatf("no-strobe hold j=%0d", j));
      end

      // R8: enable low forces low, phase kept afterwards
      @(negedge clk); ratio_sel = 4'd5; phase_sel = 5'd2; resync = 1'b1;
      @(posedge clk); #1;
      chk(div_clk, b_level(10, 5), "R8", "strobe ratio 10 offset 5");
      @(negedge clk); resync = 1'b0;
      for (int j = 1; j < 40; j++) begin
         if (j == 10) begin @(negedge clk); grp_en = 1'b0; end
         if (j == 20) begin @(negedge clk); grp_en = 1'b1; end
         @(posedge clk); #1;
         chk(div_clk, (j >= 10 && j < 20) ? 1'b0 : b_level(10, 5 + j), "R8",
             $sformatf("enable gating j=%0d", j));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule